// File: doc/BRIEF.md
# Indirect Switch Register Access Sequencer

This block sits on the host side of a management bus and turns one register request (device address, register number, direction, 16-bit data) into the raw bus accesses needed to reach a register inside a multi-port switch. When the switch's configured chip address is zero, the switch answers every bus address directly. The request then becomes one raw access, with the device address used as the bus address. For any other chip address, the switch only answers at that address. Every request is then tunnelled through a control register at offset 0 and a data register at offset 1, and the control register's busy flag is polled between steps.

Polling is bounded. A poll fails when it returns the busy flag set or when the raw access itself reports an error. After a failed poll the engine waits a fixed number of idle cycles and tries again, up to a retry limit. If the limit is reached it ends the request with an error. An error on any raw access that is not a poll aborts the request at once. Only one request is in flight at a time.

The engine is a single state machine with these states: IDLE, DIRECT, POLL, GAP, PUT_DATA, PUT_CMD, GET_DATA and FINISH.

- IDLE goes to DIRECT when a request is accepted and the chip address is zero. Otherwise it goes to POLL.
- A POLL that succeeds continues the sequence. A POLL that fails goes to GAP, or to FINISH once the limit is reached.
- GAP returns to POLL when its timer runs out.
- PUT_DATA leads to PUT_CMD, which leads to the second POLL.
- After the second POLL, a read goes to GET_DATA and a write goes to FINISH.
- A raw error in DIRECT, PUT_DATA, PUT_CMD or GET_DATA goes straight to FINISH.
- FINISH returns to IDLE.

Top module: `smi_indirect_master`

## Requirements
- R1: With chip address 0, a request produces exactly one raw access. It uses bus address = device, register = requested register, the requested direction and, for a write, the requested data. The raw error and read data become the response.
- R2: With a non-zero chip address, a read runs the following raw accesses at bus address = chip address: poll register 0 until it is not busy; write the command word to register 0; poll register 0 until it is not busy; read register 1. The response data is that 16-bit value.
- R3: With a non-zero chip address, a write runs: poll register 0 until it is not busy; write the data to register 1; write the command word to register 0; poll register 0 until it is not busy.
- R4: The command word has bit 15 = 1 (busy) and bit 12 = 1 (clause-22 flag). Bits 11:10 hold the opcode (2 = read, 1 = write), bits 9:5 the device and bits 4:0 the register. All other bits are 0. Busy is bit 15 of the value read from register 0.
- R5: A poll fails when it returns bit 15 set or a raw error. After each failed poll that is not the last allowed one, bus_req stays low for exactly POLL_GAP cycles before the poll is repeated.
- R6: After POLL_LIMIT failed polls in one poll phase, the request ends with rsp_err = 1 and no further raw access. No idle gap follows the last failed poll.
- R7: A raw error on a data write, a command write or a data read ends the request with rsp_err = 1, and no further raw access is issued.
- R8: req_ready is high only when the engine is idle. A request is accepted on a cycle where req_valid and req_ready are both high. From acceptance through the done cycle, req_ready is low and the request inputs and chip address are ignored. rsp_done is a one-cycle pulse.
- R9: At rsp_done, rsp_rdata holds the read value for a successful read and 0 for writes and for failed requests. rsp_err is 0 on success.
- R10: While reset is held and immediately after it, req_ready = 1, bus_req = 0 and rsp_done = 0.
- R11: While bus_req is high and bus_ack has not arrived, bus_req, bus_write, bus_addr, bus_reg and bus_wdata do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_addr | input | 5 | Configured switch chip address (0 selects direct mode) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, able to accept a request |
| req_dev | input | 5 | Target device address inside the switch |
| req_reg | input | 5 | Target register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request failed (raw error or poll timeout), valid at rsp_done |
| rsp_rdata | output | 16 | Read result, valid at rsp_done |
| bus_req | output | 1 | Raw access request, held until bus_ack |
| bus_write | output | 1 | Raw access direction |
| bus_addr | output | 5 | Raw bus address |
| bus_reg | output | 5 | Raw register number |
| bus_wdata | output | 16 | Raw write data |
| bus_ack | input | 1 | Raw access completed (one cycle) |
| bus_err | input | 1 | Raw access failed, valid with bus_ack |
| bus_rdata | input | 16 | Raw read data, valid with bus_ack |

## Verification
Two functions meet on one poll acknowledge: the raw-error path and the retry-limit path. They coincide when the final allowed poll returns a raw error instead of a busy flag. The bench provokes this by making every poll of a phase error out, and by a boundary case where the poll errors stop one attempt before the limit. It judges the outcome by the exact count of poll accesses, by the number of idle cycles on bus_req, and by whether the request ends with an error or goes on to the command write.

// File: rtl/smi_pkg.sv
`timescale 1ns/1ps
package smi_pkg;

    localparam int DEV_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    // Offsets of the tunnel registers inside the switch
    localparam logic [REG_W-1:0] CTRL_REG = 5'h00;
    localparam logic [REG_W-1:0] DATA_REG = 5'h01;
    localparam int               BUSY_BIT = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_POLL,
        ST_GAP,
        ST_PUT_DATA,
        ST_PUT_CMD,
        ST_GET_DATA,
        ST_FINISH
    } seq_state_t;

    // busy | clause-22 | opcode | device | register
    function automatic logic [DATA_W-1:0] build_cmd(
        input logic             is_wr,
        input logic [DEV_W-1:0] dev,
        input logic [REG_W-1:0] rg
    );
        build_cmd = {1'b1, 2'b00, 1'b1, (is_wr ? 2'b01 : 2'b10), dev, rg};
    endfunction

endpackage

// File: rtl/smi_retry_ctr.sv
`timescale 1ns/1ps
module smi_retry_ctr #(
    parameter int POLL_LIMIT = 100,
    parameter int POLL_GAP   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fail,
    input  logic gap_run,
    output logic limit_hit,
    output logic gap_last
);

    localparam int ATT_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    logic [ATT_W-1:0] att_q;
    logic [GAP_W-1:0] gap_q;

    // Attempt counter for the current poll phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_q <= '0;
        end else if (clr) begin
            att_q <= '0;
        end else if (fail) begin
            att_q <= att_q + 1'b1;
        end
    end

    // Idle-gap timer, loaded on every failed poll
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (fail) begin
            gap_q <= GAP_W'(POLL_GAP - 1);
        end else if (gap_run && (gap_q != '0)) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign limit_hit = (att_q == ATT_W'(POLL_LIMIT - 1));
    assign gap_last  = (gap_q == '0);

    // R6: attempts in one phase never run past the limit
    p_att_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        att_q <= ATT_W'(POLL_LIMIT));

    // R5: the controller stays in the gap until the timer expires
    p_gap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_run && !gap_last) |=> gap_run);

endmodule

// File: rtl/smi_seq_fsm.sv
`timescale 1ns/1ps
module smi_seq_fsm
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  chip_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [DEV_W-1:0]  bus_addr,
    output logic [REG_W-1:0]  bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cnt_clr,
    output logic              poll_fail,
    output logic              gap_run,
    input  logic              limit_hit,
    input  logic              gap_last
);

    seq_state_t st_q, st_d;

    logic [DEV_W-1:0]  dev_q, chip_q;
    logic [REG_W-1:0]  reg_q;
    logic              wr_q, post_q, err_q;
    logic [DATA_W-1:0] wd_q, rd_q;
    logic              accept, poll_ok;

    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign poll_ok   = (st_q == ST_POLL) && bus_ack && !bus_err && !bus_rdata[BUSY_BIT];
    assign poll_fail = (st_q == ST_POLL) && bus_ack && !poll_ok;
    assign cnt_clr   = accept || poll_ok;
    assign gap_run   = (st_q == ST_GAP);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d = (chip_addr == '0) ? ST_DIRECT : ST_POLL;
                end
            end
            ST_DIRECT: begin
                if (bus_ack) st_d = ST_FINISH;
            end
            ST_POLL: begin
                if (bus_ack) begin
                    if (poll_ok) begin
                        if (!post_q) st_d = wr_q ? ST_PUT_DATA : ST_PUT_CMD;
                        else         st_d = wr_q ? ST_FINISH   : ST_GET_DATA;
                    end else if (limit_hit) begin
                        st_d = ST_FINISH;
                    end else begin
                        st_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (gap_last) st_d = ST_POLL;
            end
            ST_PUT_DATA: begin
                if (bus_ack) st_d = bus_err ? ST_FINISH : ST_PUT_CMD;
            end
            ST_PUT_CMD: begin
                if (bus_ack) st_d = bus_err ? ST_FINISH : ST_POLL;
            end
            ST_GET_DATA: begin
                if (bus_ack) st_d = ST_FINISH;
            end
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q  <= '0;
            chip_q <= '0;
            reg_q  <= '0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
            post_q <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= '0;
        end else if (accept) begin
            dev_q  <= req_dev;
            chip_q <= chip_addr;
            reg_q  <= req_reg;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            post_q <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= '0;
        end else if (bus_ack) begin
            unique case (st_q)
                ST_DIRECT: begin
                    err_q <= bus_err;
                    if (!wr_q && !bus_err) rd_q <= bus_rdata;
                end
                ST_POLL: begin
                    if (poll_fail && limit_hit) err_q <= 1'b1;
                end
                ST_PUT_DATA: begin
                    if (bus_err) err_q <= 1'b1;
                end
                ST_PUT_CMD: begin
                    if (bus_err) err_q  <= 1'b1;
                    else         post_q <= 1'b1;
                end
                ST_GET_DATA: begin
                    if (bus_err) err_q <= 1'b1;
                    else         rd_q  <= bus_rdata;
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = chip_q;
        bus_reg   = CTRL_REG;
        bus_wdata = '0;
        unique case (st_q)
            ST_DIRECT: begin
                bus_req   = 1'b1;
                bus_write = wr_q;
                bus_addr  = dev_q;
                bus_reg   = reg_q;
                bus_wdata = wr_q ? wd_q : '0;
            end
            ST_POLL: begin
                bus_req = 1'b1;
            end
            ST_PUT_DATA: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_reg   = DATA_REG;
                bus_wdata = wd_q;
            end
            ST_PUT_CMD: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_wdata = build_cmd(wr_q, dev_q, reg_q);
            end
            ST_GET_DATA: begin
                bus_req = 1'b1;
                bus_reg = DATA_REG;
            end
            default: ;
        endcase
    end

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_done  = (st_q == ST_FINISH);
    assign rsp_err   = err_q;
    assign rsp_rdata = rd_q;

    // R11: raw access held steady until acknowledged
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_reg)
                                   && $stable(bus_wdata) && $stable(bus_write)));

    // R11: an acknowledge only answers a pending access
    p_ack_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_req);

    // R8: done lasts one cycle and is followed by readiness
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    // R8: no raw traffic while idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req);

    // R9: a failed request returns zero data
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (rsp_rdata == '0));

endmodule

// File: rtl/smi_indirect_master.sv
`timescale 1ns/1ps
module smi_indirect_master
    import smi_pkg::*;
#(
    parameter int POLL_LIMIT = 100,
    parameter int POLL_GAP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  chip_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [DEV_W-1:0]  bus_addr,
    output logic [REG_W-1:0]  bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic cnt_clr, poll_fail, gap_run, limit_hit, gap_last;

    smi_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_addr (chip_addr),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_dev   (req_dev),
        .req_reg   (req_reg),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .cnt_clr   (cnt_clr),
        .poll_fail (poll_fail),
        .gap_run   (gap_run),
        .limit_hit (limit_hit),
        .gap_last  (gap_last)
    );

    smi_retry_ctr #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .fail      (poll_fail),
        .gap_run   (gap_run),
        .limit_hit (limit_hit),
        .gap_last  (gap_last)
    );

endmodule

// File: tb/smi_indirect_master_tb_top.sv
`timescale 1ns/1ps
module smi_indirect_master_tb_top;

    localparam int LIM = 100;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  chip_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_req, bus_write;
    logic [4:0]  bus_addr, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [15:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    smi_indirect_master #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
        .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- switch model on the raw bus ----------------
    int          busy_left, busy_post, perr_left, fail_kind, lat, lcnt;
    int          chip_cfg, stab_bad;
    bit          direct_fail;
    logic [15:0] r1_val, direct_val;

    logic        lg_wr   [0:511];
    logic [4:0]  lg_addr [0:511];
    logic [4:0]  lg_reg  [0:511];
    logic [15:0] lg_wd   [0:511];
    int          lg_n;

    logic        ex_wr   [0:511];
    logic [4:0]  ex_addr [0:511];
    logic [4:0]  ex_reg  [0:511];
    logic [15:0] ex_wd   [0:511];
    bit          ex_cmd  [0:511];
    int          ex_n;

    bit          p_pend;
    logic        p_wr;
    logic [4:0]  p_addr, p_reg;
    logic [15:0] p_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            lcnt    = 0;
            p_pend  = 1'b0;
        end else begin
            if (p_pend && (!bus_req || bus_write != p_wr || bus_addr != p_addr ||
                           bus_reg != p_reg || bus_wdata != p_wd))
                stab_bad++;
            p_pend = bus_req && !bus_ack;
            p_wr = bus_write; p_addr = bus_addr; p_reg = bus_reg; p_wd = bus_wdata;

            if (bus_ack) begin
                bus_ack <= 1'b0;
                bus_err <= 1'b0;
                lcnt = 0;
            end else if (bus_req) begin
                if (lcnt < lat) begin
                    lcnt++;
                end else begin
                    logic        e;
                    logic [15:0] d;
                    e = 1'b0;
                    d = 16'($urandom);
                    if (lg_n < 512) begin
                        lg_wr[lg_n] = bus_write; lg_addr[lg_n] = bus_addr;
                        lg_reg[lg_n] = bus_reg;  lg_wd[lg_n] = bus_wdata;
                        lg_n++;
                    end
                    if (chip_cfg == 0) begin
                        e = direct_fail;
                        d = direct_val;
                    end else if (!bus_write && bus_reg == 5'd0) begin
                        if (perr_left > 0) begin
                            perr_left--; e = 1'b1;
                        end else if (busy_left > 0) begin
                            busy_left--; d = d | 16'h8000;
                        end else begin
                            d = d & 16'h7fff;
                        end
                    end else if (bus_write && bus_reg == 5'd0) begin
                        e = (fail_kind == 2);
                        busy_left = busy_post;
                    end else if (bus_write && bus_reg == 5'd1) begin
                        e = (fail_kind == 1);
                    end else begin
                        e = (fail_kind == 3);
                        d = r1_val;
                    end
                    bus_ack   <= 1'b1;
                    bus_err   <= e;
                    bus_rdata <= d;
                    lat = $urandom_range(0, 2);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input bit w, input logic [4:0] dv, input logic [4:0] rg);
        exp_cmd = 16'h9000 | (w ? 16'h0400 : 16'h0800) | (16'(dv) << 5) | 16'(rg);
    endfunction

    task automatic push(input bit w, input logic [4:0] a, input logic [4:0] r,
                        input logic [15:0] d, input bit c);
        ex_wr[ex_n] = w; ex_addr[ex_n] = a; ex_reg[ex_n] = r; ex_wd[ex_n] = d; ex_cmd[ex_n] = c;
        ex_n++;
    endtask

    // one poll phase: returns 1 on timeout
    task automatic exp_poll(input logic [4:0] chip, input int nfail,
                            inout int gaps, output bit tmo);
        int n;
        tmo = (nfail >= LIM);
        n = tmo ? LIM : nfail + 1;
        for (int i = 0; i < n; i++) push(1'b0, chip, 5'd0, 16'h0, 1'b0);
        gaps += tmo ? (LIM - 1) * GAP : nfail * GAP;
    endtask

    // ---------------- one request ----------------
    task automatic run_txn(input logic [4:0] chip, input logic [4:0] dv, input logic [4:0] rg,
                           input bit wr, input logic [15:0] wd, input int b1, input int b2,
                           input int pe, input int fk, input bit dfail);
        int cycles, gaps, rdy_bad, ex_gaps;
        bit exp_err, tmo;
        logic [15:0] exp_rd;
        logic [15:0] got_rd;
        bit got_err, got_rdy;
        string mtag, etag;

        @(negedge clk);
        busy_left = b1; busy_post = b2; perr_left = pe; fail_kind = fk;
        direct_fail = dfail; r1_val = 16'($urandom); direct_val = 16'($urandom);
        chip_cfg = int'(chip); lg_n = 0; stab_bad = 0;
        chip_addr = chip; req_dev = dv; req_reg = rg; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        // scribble inputs while busy: must be ignored (R8)
        chip_addr = 5'($urandom); req_dev = 5'($urandom); req_reg = 5'($urandom);
        req_write = 1'($urandom); req_wdata = 16'($urandom);
        cycles = 0; gaps = 0; rdy_bad = 0;
        while (!rsp_done && cycles < 20000) begin
            if (req_ready) rdy_bad++;
            if (!bus_req) gaps++;
            @(negedge clk);
            cycles++;
        end
        got_err = rsp_err; got_rd = rsp_rdata; got_rdy = req_ready;
        chk(rsp_done == 1'b1, "R8", "done reached", rsp_done, 1);
        chk(rdy_bad == 0 && got_rdy == 1'b0, "R8", "ready low while busy", rdy_bad, 0);
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R8", "done is one-cycle pulse",
            {rsp_done, req_ready}, 2'b01);

        // expected sequence from the requirements
        ex_n = 0; ex_gaps = 0; exp_err = 0; exp_rd = 16'h0;
        etag = "R7";
        if (chip == 5'd0) begin
            mtag = "R1";
            push(wr, dv, rg, wr ? wd : 16'h0, 1'b0);
            exp_err = dfail;
            exp_rd = (wr || dfail) ? 16'h0 : direct_val;
            etag = "R1";
        end else begin
            mtag = wr ? "R3" : "R2";
            exp_poll(chip, pe + b1, ex_gaps, tmo);
            if (tmo) begin
                exp_err = 1; etag = "R6";
            end else begin
                if (wr) begin
                    push(1'b1, chip, 5'd1, wd, 1'b0);
                    if (fk == 1) exp_err = 1;
                end
                if (!exp_err) begin
                    push(1'b1, chip, 5'd0, exp_cmd(wr, dv, rg), 1'b1);
                    if (fk == 2) exp_err = 1;
                end
                if (!exp_err) begin
                    exp_poll(chip, b2, ex_gaps, tmo);
                    if (tmo) begin exp_err = 1; etag = "R6"; end
                end
                if (!exp_err && !wr) begin
                    push(1'b0, chip, 5'd1, 16'h0, 1'b0);
                    if (fk == 3) exp_err = 1;
                    else exp_rd = r1_val;
                end
            end
        end

        chk(lg_n == ex_n, (etag == "R6") ? "R6" : mtag, "raw access count", lg_n, ex_n);
        if (lg_n == ex_n) begin
            int bad;
            bad = -1;
            for (int i = 0; i < ex_n; i++) begin
                if (bad < 0 && (lg_wr[i] != ex_wr[i] || lg_addr[i] != ex_addr[i] ||
                                lg_reg[i] != ex_reg[i] || lg_wd[i] != ex_wd[i]))
                    bad = i;
            end
            if (bad < 0) chk(1'b1, mtag, "sequence", 0, 0);
            else chk(1'b0, ex_cmd[bad] ? "R4" : mtag, "access word",
                     {lg_wr[bad], lg_addr[bad], lg_reg[bad], lg_wd[bad]},
                     {ex_wr[bad], ex_addr[bad], ex_reg[bad], ex_wd[bad]});
        end
        chk(got_err == exp_err, exp_err ? etag : "R9", "rsp_err", got_err, exp_err);
        chk(got_rd == exp_rd, "R9", "rsp_rdata", got_rd, exp_rd);
        chk(gaps == ex_gaps, "R5", "idle gap cycles", gaps, ex_gaps);
        chk(stab_bad == 0, "R11", "held request", stab_bad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1f2e3d4c);
        lat = 0; lg_n = 0; stab_bad = 0; chip_cfg = 0;
        busy_left = 0; busy_post = 0; perr_left = 0; fail_kind = 0;
        direct_fail = 0; r1_val = 0; direct_val = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b1 && bus_req == 1'b0 && rsp_done == 1'b0, "R10", "state in reset",
            {req_ready, bus_req, rsp_done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_req == 1'b0 && rsp_done == 1'b0, "R10", "state after reset",
            {req_ready, bus_req, rsp_done}, 3'b100);

        // R1 direct read, direct write with raw error
        run_txn(5'd0, 5'd3, 5'd7, 1'b0, 16'h0, 0, 0, 0, 0, 1'b0);
        run_txn(5'd0, 5'd17, 5'd4, 1'b1, 16'hbeef, 0, 0, 0, 0, 1'b1);
        // R2/R4 plain indirect read, R3 write with busy in both phases
        run_txn(5'd5, 5'd12, 5'd3, 1'b0, 16'h0, 0, 0, 0, 0, 1'b0);
        run_txn(5'd31, 5'd31, 5'd31, 1'b1, 16'ha5c3, 3, 2, 0, 0, 1'b0);
        // R6 timeout in first and second poll phases
        run_txn(5'd9, 5'd1, 5'd2, 1'b0, 16'h0, 1000, 0, 0, 0, 1'b0);
        run_txn(5'd9, 5'd2, 5'd16, 1'b1, 16'h1234, 0, 1000, 0, 0, 1'b0);
        // R6 raw error on the last allowed poll; R5 success on the last attempt
        run_txn(5'd4, 5'd6, 5'd0, 1'b0, 16'h0, 0, 0, LIM, 0, 1'b0);
        run_txn(5'd4, 5'd6, 5'd0, 1'b0, 16'h0, 0, 0, LIM - 1, 0, 1'b0);
        run_txn(5'd4, 5'd8, 5'd9, 1'b1, 16'h0f0f, 1, 0, LIM - 2, 0, 1'b0);
        // R7 abort on data write, command write, data read
        run_txn(5'd7, 5'd10, 5'd11, 1'b1, 16'h5555, 1, 0, 0, 1, 1'b0);
        run_txn(5'd7, 5'd10, 5'd11, 1'b0, 16'h0, 0, 0, 1, 2, 1'b0);
        run_txn(5'd7, 5'd10, 5'd11, 1'b0, 16'h0, 0, 1, 0, 3, 1'b0);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [4:0] c;
            int fk;
            c = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            fk = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 3) : 0;
            run_txn(c, 5'($urandom), 5'($urandom), 1'($urandom), 16'($urandom),
                    $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 2),
                    fk, ($urandom_range(0, 5) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule